// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

The block counts ticks from a free-running oscillator enable input. It asserts a system reset pulse when software fails to restart it within the selected interval. A 3-bit scale field picks one of eight intervals. Each step of the field doubles the interval, starting from 2^BASE_EXP ticks. A restart strobe, raised when the processor executes its watchdog-restart instruction, returns the count to zero.

Software sets the enable bit, the disarm-key bit and the scale through an 8-bit control register, and reads them back on the same port. Setting the enable bit needs only one write. Clearing it needs two: a first write sets the key bit and the enable bit together, which opens a short window. A second write inside that window, with the enable bit at zero, then stops the watchdog. A write that clears the enable bit without an open window does not stop it. This protects the watchdog against a single stray write.

When the watchdog expires, it drives the reset output high for a fixed number of cycles. The count is held at zero during that pulse, so timing restarts from zero once the pulse ends.

Top module: `wdog_guard`

## Requirements
- R1: When reset is released, `rd_data` reads 0x00 and `wdt_reset` is low.
- R2: `rd_data` presents the control register in this layout: bits 7..5 always read zero, bit 4 is the disarm key (1 while the unlock window is open), bit 3 is the enable bit, and bits 2..0 are the scale. Every write loads the scale from `wr_data[2:0]`.
- R3: While enabled, the watchdog expires on the 2^(BASE_EXP+scale)-th `tick` after the count was last cleared. Cycles without `tick` do not advance the count.
- R4: A `kick` clears the count. When `kick` and `tick` coincide, the clear wins and no expiry happens in that cycle.
- R5: An expiry drives `wdt_reset` high for exactly PULSE_LEN cycles, starting in the cycle after the expiring tick. Ticks and kicks during the pulse are ignored, and the next interval counts from zero.
- R6: While the enable bit is 0, `wdt_reset` stays low however many ticks arrive.
- R7: A write with bit 3 at 0 leaves the enable bit set when no unlock window is open. This includes a write with bit 4 at 1 and bit 3 at 0.
- R8: A write with bits 4 and 3 both at 1 sets the enable bit and opens an unlock window. Bit 4 then reads 1 for exactly UNLOCK_WIN cycles and clears itself.
- R9: A write with bit 3 at 0 made while the window is open clears the enable bit and closes the window. The same write one cycle after the window closes leaves the enable bit set.
- R10: If the scale is lowered below the current count, the next tick expires the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| kick | input | 1 | Restart strobe from the watchdog-restart instruction |
| tick | input | 1 | One-cycle enable from the watchdog oscillator |
| wdt_reset | output | 1 | System reset pulse |

## Verification
The bench builds the block with BASE_EXP=3, PULSE_LEN=6 and UNLOCK_WIN=4. The eight intervals then span 8 to 1024 ticks, so the shortest interval, a middle one with sparse ticks and the longest one can all be measured to the exact tick. The narrow window makes the last valid clearing write and the first late one only one cycle apart. The short pulse lets the bench chain several expiries, each followed by a fresh interval counted from zero.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

    localparam int REG_W   = 8;
    localparam int SCALE_W = 3;
    localparam int KEY_BIT = 4;
    localparam int RUN_BIT = 3;
    localparam int SCALE_MAX = (1 << SCALE_W) - 1;

    typedef logic [SCALE_W-1:0] scale_t;

    typedef struct packed {
        logic   run;
        scale_t scale;
    } ctrl_cfg_t;

    typedef struct packed {
        logic [2:0] rsv;
        logic       key;
        logic       run;
        scale_t     scale;
    } ctrl_view_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ARM_KEY,
        WR_DISARM,
        WR_PLAIN
    } wr_kind_t;

    function automatic wr_kind_t classify_write(
        input logic       wr,
        input logic [4:0] d,
        input logic       win_open
    );
        if (!wr) return WR_NONE;
        if (d[KEY_BIT] && d[RUN_BIT]) return WR_ARM_KEY;
        if (win_open && !d[RUN_BIT]) return WR_DISARM;
        return WR_PLAIN;
    endfunction

    function automatic ctrl_view_t make_view(input ctrl_cfg_t c, input logic key);
        ctrl_view_t v;
        v.rsv   = '0;
        v.key   = key;
        v.run   = c.run;
        v.scale = c.scale;
        return v;
    endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_guard_pkg::*;
#(
    parameter int UNLOCK_WIN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [4:0] wr_bits,
    output ctrl_cfg_t  cfg,
    output logic       key_open
);
    localparam int WIN_W = $clog2(UNLOCK_WIN + 1);

    ctrl_cfg_t        cfg_q;
    logic [WIN_W-1:0] win_q;
    wr_kind_t         kind;

    assign key_open = (win_q != '0);

    always_comb begin
        kind = classify_write(wr_en, wr_bits, key_open);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            win_q <= '0;
        end else begin
            case (kind)
                WR_ARM_KEY: begin
                    cfg_q.run   <= 1'b1;
                    cfg_q.scale <= wr_bits[SCALE_W-1:0];
                    win_q       <= WIN_W'(UNLOCK_WIN);
                end
                WR_DISARM: begin
                    cfg_q.run   <= 1'b0;
                    cfg_q.scale <= wr_bits[SCALE_W-1:0];
                    win_q       <= '0;
                end
                WR_PLAIN: begin
                    cfg_q.run   <= cfg_q.run | wr_bits[RUN_BIT];
                    cfg_q.scale <= wr_bits[SCALE_W-1:0];
                    if (key_open) win_q <= win_q - 1'b1;
                end
                default: begin
                    if (key_open) win_q <= win_q - 1'b1;
                end
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
    import wdog_guard_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  scale_t scale,
    input  logic   kick,
    input  logic   tick,
    input  logic   hold,
    output logic   expire
);
    localparam int CNT_W = BASE_EXP + SCALE_MAX + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    // last count value before expiry for the selected scale
    always_comb begin
        last_q = (CNT_W'(1) << (BASE_EXP + int'(scale))) - CNT_W'(1);
    end

    // >= covers a scale lowered below the running count
    assign expire = run && !hold && !kick && tick && (cnt_q >= last_q);

    always_ff @(posedge clk) begin
        if (rst || !run || hold || kick || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);
    localparam int P_W = $clog2(PULSE_LEN + 1);

    logic [P_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= P_W'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_guard_pkg::*;
#(
    parameter int BASE_EXP   = 14,
    parameter int UNLOCK_WIN = 4,
    parameter int PULSE_LEN  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             kick,
    input  logic             tick,
    output logic             wdt_reset
);
    ctrl_cfg_t  cfg;
    logic       key_open;
    logic       expire;
    logic       pulse_on;
    ctrl_view_t view;
    logic       unused_rsv;

    assign unused_rsv = ^wr_data[REG_W-1:5];

    wdog_ctrl_reg #(.UNLOCK_WIN(UNLOCK_WIN)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bits  (wr_data[4:0]),
        .cfg      (cfg),
        .key_open (key_open)
    );

    wdog_tick_counter #(.BASE_EXP(BASE_EXP)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .run    (cfg.run),
        .scale  (cfg.scale),
        .kick   (kick),
        .tick   (tick),
        .hold   (pulse_on),
        .expire (expire)
    );

    wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
        .clk    (clk),
        .rst    (rst),
        .fire   (expire),
        .active (pulse_on)
    );

    assign view      = make_view(cfg, key_open);
    assign rd_data   = view;
    assign wdt_reset = pulse_on;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int UNLOCK_WIN = 4,
    parameter int PULSE_LEN  = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       kick,
    input logic       tick,
    input logic       wdt_reset
);
    int unsigned hi_len;
    int unsigned key_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len  <= 0;
            key_len <= 0;
        end else begin
            hi_len  <= wdt_reset  ? hi_len + 1  : 0;
            key_len <= rd_data[4] ? key_len + 1 : 0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !wdt_reset));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);

    // R4
    kick_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (kick && !wdt_reset) |=> !wdt_reset);

    // R5
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_reset |-> hi_len < PULSE_LEN);

    // R5
    pulse_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_reset) |-> hi_len == PULSE_LEN);

    // R6
    needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_reset) |-> ($past(rd_data[3]) && $past(tick)));

    // R8
    key_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[4]) |-> $past(wr_en && wr_data[4] && wr_data[3]));

    // R8
    key_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> key_len < UNLOCK_WIN);

    // R9
    guarded_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[3]) |-> ($past(rd_data[4]) && $past(wr_en) && !$past(wr_data[3])));

endmodule

bind wdog_guard wdog_guard_chk #(
    .UNLOCK_WIN (UNLOCK_WIN),
    .PULSE_LEN  (PULSE_LEN)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .kick      (kick),
    .tick      (tick),
    .wdt_reset (wdt_reset)
);

// File: tb/wdog_guard_tb_top.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
    localparam int BASE_EXP   = 3;
    localparam int UNLOCK_WIN = 4;
    localparam int PULSE_LEN  = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       kick;
    logic       tick;
    logic       wdt_reset;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wdog_guard #(
        .BASE_EXP   (BASE_EXP),
        .UNLOCK_WIN (UNLOCK_WIN),
        .PULSE_LEN  (PULSE_LEN)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .kick      (kick),
        .tick      (tick),
        .wdt_reset (wdt_reset)
    );

    // ---------------- behavioural reference ----------------
    int m_count, m_pulse, m_run, m_scale, m_win;
    int o_pulse, o_run, o_win, lim;
    bit fire;

    always @(posedge clk) begin
        if (rst) begin
            m_count = 0; m_pulse = 0; m_run = 0; m_scale = 0; m_win = 0;
        end else begin
            o_pulse = m_pulse; o_run = m_run; o_win = m_win;
            lim  = 1 << (BASE_EXP + m_scale);
            fire = (o_pulse == 0) && (o_run != 0) && !kick && tick && (m_count + 1 >= lim);
            if (o_pulse != 0 || o_run == 0 || kick || fire) m_count = 0;
            else if (tick) m_count = m_count + 1;
            if (fire) m_pulse = PULSE_LEN;
            else if (o_pulse > 0) m_pulse = o_pulse - 1;
            if (wr_en) begin
                m_scale = int'(wr_data[2:0]);
                if (wr_data[4] && wr_data[3]) begin
                    m_run = 1; m_win = UNLOCK_WIN;
                end else if (o_win > 0 && !wr_data[3]) begin
                    m_run = 0; m_win = 0;
                end else begin
                    m_run = (o_run != 0 || wr_data[3]) ? 1 : 0;
                    if (o_win > 0) m_win = o_win - 1;
                end
            end else if (o_win > 0) begin
                m_win = o_win - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [7:0] exp_rd;
    always @(negedge clk) begin
        if (!rst && !done) begin
            exp_rd = {3'b000, m_win != 0, m_run != 0, 3'(m_scale)};
            chk(rd_data[4] == exp_rd[4], "R8 key bit", rd_data, exp_rd);
            chk(rd_data[3] == exp_rd[3], "R9 enable bit", rd_data, exp_rd);
            chk({rd_data[7:5], rd_data[2:0]} == {exp_rd[7:5], exp_rd[2:0]}, "R2 fields", rd_data, exp_rd);
            chk(wdt_reset == (m_pulse != 0), "R3 reset output", wdt_reset, m_pulse != 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        step();
        kick = 1'b0;
    endtask

    task automatic ticks_to_reset(input int gap, output int n);
        int i = 0;
        n = 0;
        while (!wdt_reset && n < 5000) begin
            tick = (i % gap == 0);
            if (tick) n++;
            step();
            tick = 1'b0;
            i++;
        end
    endtask

    task automatic pulse_len(output int len);
        len = 0;
        while (wdt_reset && len < 100) begin
            tick = 1'b1; kick = (len == 2);
            step();
            len++;
        end
        tick = 1'b0; kick = 1'b0;
    endtask

    int n, len;
    bit seen;

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; kick = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 8'h00 && !wdt_reset, "R1", rd_data, 0);

        wr(8'hEF);
        chk(rd_data == 8'h0F, "R2", rd_data, 8'h0F);

        // R3: shortest interval, tick each cycle
        wr(8'h08); do_kick();
        ticks_to_reset(1, n);
        chk(n == 8, "R3 scale0", n, 8);
        // R5: pulse length and restart from zero
        pulse_len(len);
        chk(len == PULSE_LEN, "R5 length", len, PULSE_LEN);
        ticks_to_reset(1, n);
        chk(n == 8, "R5 restart", n, 8);
        pulse_len(len);

        // R3: scale 2, sparse ticks
        wr(8'h0A); do_kick();
        ticks_to_reset(3, n);
        chk(n == 32, "R3 scale2", n, 32);
        pulse_len(len);

        // R3: longest interval
        wr(8'h0F); do_kick();
        ticks_to_reset(1, n);
        chk(n == 1024, "R3 scale7", n, 1024);
        pulse_len(len);

        // R4: kick together with tick clears count
        wr(8'h08); do_kick();
        tick = 1'b1; repeat (5) step();
        kick = 1'b1; step(); kick = 1'b0; tick = 1'b0;
        ticks_to_reset(1, n);
        chk(n == 8, "R4 kick+tick", n, 8);
        pulse_len(len);
        seen = 0;
        for (int r = 0; r < 20; r++) begin
            tick = 1'b1;
            repeat (6) begin step(); if (wdt_reset) seen = 1; end
            tick = 1'b0;
            do_kick();
            if (wdt_reset) seen = 1;
        end
        chk(!seen, "R4 periodic", seen, 0);

        // R7: clearing writes without a window
        wr(8'h00);
        chk(rd_data == 8'h08, "R7 plain", rd_data, 8'h08);
        wr(8'h10);
        chk(rd_data == 8'h08, "R7 key-only", rd_data, 8'h08);
        wr(8'h13);
        chk(rd_data == 8'h0B, "R7 key-only scale", rd_data, 8'h0B);

        // R8: window lasts exactly UNLOCK_WIN cycles
        wr(8'h1A);
        for (int k = 0; k < UNLOCK_WIN; k++) begin
            chk(rd_data == 8'h1A, "R8 open", rd_data, 8'h1A);
            step();
        end
        chk(rd_data == 8'h0A, "R8 closed", rd_data, 8'h0A);

        // R9: last valid cycle, then first late cycle
        wr(8'h18); repeat (UNLOCK_WIN - 1) step();
        wr(8'h02);
        chk(rd_data == 8'h02, "R9 in window", rd_data, 8'h02);
        wr(8'h18); repeat (UNLOCK_WIN) step();
        wr(8'h00);
        chk(rd_data == 8'h08, "R9 late", rd_data, 8'h08);

        // R6: disabled watchdog never resets
        wr(8'h18); wr(8'h00);
        chk(rd_data == 8'h00, "R6 disabled", rd_data, 8'h00);
        seen = 0; tick = 1'b1;
        repeat (2000) begin step(); if (wdt_reset) seen = 1; end
        tick = 1'b0;
        chk(!seen, "R6 no reset", seen, 0);

        // R10: lower scale below the running count
        wr(8'h0F); do_kick();
        tick = 1'b1; repeat (100) step(); tick = 1'b0;
        chk(!wdt_reset, "R10 before", wdt_reset, 0);
        wr(8'h08);
        tick = 1'b1; step(); tick = 1'b0;
        chk(wdt_reset == 1'b1, "R10 expire", wdt_reset, 1);
        pulse_len(len);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL R3 watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule